// File: doc/BRIEF.md
# Indexed Statistics Counter Window

This block keeps a set of per-port traffic counters and exposes them to a host through a narrow, indirect register window. Each port has a small group of 32-bit event counters, each advanced by a strobe input, and one 64-bit byte counter advanced by a length input. A counter only moves while its port's enable bit is set.

To read a counter, the host first writes a counter index into an index register. It then writes the control register with the start bit set, the operation-mode bit cleared and a port number. The engine holds the start bit high while it fetches the 32-bit entry, then clears it. In the same cycle that the start bit clears, it loads the result into two 16-bit value registers. The 64-bit byte counter occupies two adjacent indices: the low word sits at the base index and the high word at the next index. Every index from 0x00 to 0x27 can be read. Indices that have no counter behind them read as zero.

Top module: `stat_counter_window`

## Requirements
- R1: After reset, the value registers, the control register and every port enable read as zero. Every counter starts at zero.
- R2: A write to the control register (offset 0x05) with bit 15 set and bit 5 clear starts a read of the port in bits 4:0 at the index held in the index register (offset 0x04). Bit 15 then reads 1 for exactly two cycles after the write edge and 0 after that. The value registers change only in the cycle that bit 15 clears.
- R3: The fetched 32-bit word appears with bits 15:0 at offset 0x03 and bits 31:16 at offset 0x02.
- R4: Port p has an enable bit at bit 0 of offset 0x08+p. While the enable is set, each cycle that event strobe e of port p is high adds one to the counter at index e of that port. While the enable is clear, the strobe has no effect. Counters of other ports and other indices are not affected.
- R5: Each cycle that a port's byte-valid input is high adds its length input to that port's 64-bit byte counter. The low word reads at index 0x24 and the high word at index 0x25, and a carry out of the low word reaches the high word.
- R6: An increment that lands in the cycle the engine samples the entry (the first busy cycle) is kept. The read returns the value from before that increment, and a later read returns the incremented value.
- R7: A control write with bit 5 set starts no read. Bit 15 stays 0 and the value registers keep their contents.
- R8: While a read is in progress, further control writes are ignored, and neither they nor index-register writes alter the result of that read.
- R9: An index with no counter behind it, an index above 0x27, and a port number at or above the port count all return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 6 | Host register offset, used for both reads and writes |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr (combinational) |
| evt_stb | input | NUM_PORTS*NUM_EVT | Event strobes; bit p*NUM_EVT+e advances counter e of port p |
| byte_vld | input | NUM_PORTS | Byte-count valid, one bit per port |
| byte_len | input | NUM_PORTS*LEN_W | Length added to the byte counter; slice p belongs to port p |

## Verification
The bench targets the following corner cases, each paired with what a faulty design would show:
- Off-by-one latency: a design that clears the busy bit one cycle early or late, or loads the value registers before the bit clears, shows a wrong busy bit or a premature value when polled in each cycle of a read.
- Collision: a strobe timed to land exactly on the sampling cycle catches a design that returns the post-increment value, or one that drops the increment.
- Byte-counter carry: 65537 additions of 0xFFFF followed by an addition of 2 expose a design that loses the carry into the high word.
- Ignored writes and out-of-range selectors: a second control write and an index write during a busy read, a start with the mode bit set, empty indices, and a port past the last one catch a design that restarts, redirects, or returns stale data for these cases.

// File: rtl/stat_win_pkg.sv
package stat_win_pkg;
  localparam int unsigned HADDR_W = 6;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned IDX_W   = 6;
  localparam int unsigned PFLD_W  = 5;
  localparam int unsigned START_BIT = 15;
  localparam int unsigned MODE_BIT  = 5;

  localparam logic [HADDR_W-1:0] OFS_VAL_HI = 6'h02;
  localparam logic [HADDR_W-1:0] OFS_VAL_LO = 6'h03;
  localparam logic [HADDR_W-1:0] OFS_INDEX  = 6'h04;
  localparam logic [HADDR_W-1:0] OFS_CTRL   = 6'h05;
  localparam logic [HADDR_W-1:0] OFS_PCFG   = 6'h08;
endpackage

// File: rtl/stat_port_bank.sv
module stat_port_bank #(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned SLOT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [NUM_EVT-1:0] evt_stb,
  input  logic              byte_vld,
  input  logic [LEN_W-1:0]  byte_len,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [31:0]       rd_word
);
  localparam int unsigned EW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [SLOT_W-1:0] SLOT_BLO = SLOT_W'(NUM_EVT);
  localparam logic [SLOT_W-1:0] SLOT_BHI = SLOT_W'(NUM_EVT + 1);

  logic [NUM_EVT-1:0][31:0] evt_q;
  logic [NUM_EVT-1:0][31:0] evt_d;
  logic [NUM_EVT-1:0]       evt_ce;
  logic [63:0]              byte_q;
  logic [63:0]              byte_d;
  logic                     byte_ce;

  genvar e;
  generate
    for (e = 0; e < NUM_EVT; e++) begin : g_evt
      always_comb begin
        evt_ce[e] = cnt_en & evt_stb[e];
        evt_d[e]  = evt_q[e] + 32'd1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          evt_q[e] <= '0;
        end else if (evt_ce[e]) begin
          evt_q[e] <= evt_d[e];
        end
      end
    end
  endgenerate

  always_comb begin
    byte_ce = cnt_en & byte_vld;
    byte_d  = byte_q + 64'(byte_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (byte_ce) begin
      byte_q <= byte_d;
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_slot < SLOT_BLO) begin
      rd_word = evt_q[rd_slot[EW-1:0]];
    end else if (rd_slot == SLOT_BLO) begin
      rd_word = byte_q[31:0];
    end else if (rd_slot == SLOT_BHI) begin
      rd_word = byte_q[63:32];
    end
  end
endmodule

// File: rtl/stat_read_engine.sv
module stat_read_engine
  import stat_win_pkg::*;
#(
  parameter int unsigned     NUM_PORTS = 4,
  parameter int unsigned     NUM_EVT   = 4,
  parameter int unsigned     SLOT_W    = 3,
  parameter logic [IDX_W-1:0] BYTE_IDX = 6'h24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [PFLD_W-1:0]             req_port,
  input  logic [IDX_W-1:0]              req_idx,
  input  logic [NUM_PORTS-1:0][31:0]    bank_word,
  output logic [SLOT_W-1:0]             rd_slot,
  output logic                          busy,
  output logic [31:0]                   value
);
  localparam int unsigned PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam logic [PFLD_W-1:0] PORT_LIM  = PFLD_W'(NUM_PORTS);
  localparam logic [IDX_W-1:0]  EVT_LIM   = IDX_W'(NUM_EVT);
  localparam logic [SLOT_W-1:0] SLOT_NONE = SLOT_W'(NUM_EVT + 2);

  logic              busy_q, busy_d;
  logic              stg_q, stg_d;
  logic [PFLD_W-1:0] port_q, port_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [31:0]       data_q, data_d;
  logic [31:0]       val_q, val_d;
  logic [31:0]       word_sel;

  // index to bank slot
  always_comb begin
    if (idx_q < EVT_LIM) begin
      rd_slot = idx_q[SLOT_W-1:0];
    end else if (idx_q == BYTE_IDX) begin
      rd_slot = SLOT_W'(NUM_EVT);
    end else if (idx_q == BYTE_IDX + 6'd1) begin
      rd_slot = SLOT_W'(NUM_EVT + 1);
    end else begin
      rd_slot = SLOT_NONE;
    end
  end

  always_comb begin
    word_sel = '0;
    if (port_q < PORT_LIM) begin
      word_sel = bank_word[port_q[PSEL_W-1:0]];
    end
  end

  always_comb begin
    busy_d = busy_q;
    stg_d  = stg_q;
    port_d = port_q;
    idx_d  = idx_q;
    data_d = data_q;
    val_d  = val_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        stg_d  = 1'b0;
        port_d = req_port;
        idx_d  = req_idx;
      end
    end else if (!stg_q) begin
      data_d = word_sel;
      stg_d  = 1'b1;
    end else begin
      val_d  = data_q;
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      stg_q  <= 1'b0;
      port_q <= '0;
      idx_q  <= '0;
      data_q <= '0;
      val_q  <= '0;
    end else begin
      busy_q <= busy_d;
      stg_q  <= stg_d;
      port_q <= port_d;
      idx_q  <= idx_d;
      data_q <= data_d;
      val_q  <= val_d;
    end
  end

  assign busy  = busy_q;
  assign value = val_q;
endmodule

// File: rtl/stat_counter_window.sv
module stat_counter_window
  import stat_win_pkg::*;
#(
  parameter int unsigned      NUM_PORTS = 4,
  parameter int unsigned      NUM_EVT   = 4,
  parameter int unsigned      LEN_W     = 16,
  parameter logic [IDX_W-1:0] BYTE_IDX  = 6'h24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_wr,
  input  logic [HADDR_W-1:0]           host_addr,
  input  logic [REG_W-1:0]             host_wdata,
  output logic [REG_W-1:0]             host_rdata,
  input  logic [NUM_PORTS*NUM_EVT-1:0] evt_stb,
  input  logic [NUM_PORTS-1:0]         byte_vld,
  input  logic [NUM_PORTS*LEN_W-1:0]   byte_len
);
  localparam int unsigned SLOT_W = $clog2(NUM_EVT + 3);

  logic                      rst_s1, rst_s2, rst_sync_n;
  logic [IDX_W-1:0]          index_q, index_d;
  logic                      mode_q, mode_d;
  logic [PFLD_W-1:0]         cport_q, cport_d;
  logic [NUM_PORTS-1:0]      pen_q, pen_d;
  logic                      wr_ctrl;
  logic                      eng_start;
  logic                      eng_busy;
  logic [31:0]               eng_value;
  logic [SLOT_W-1:0]         rd_slot;
  logic [NUM_PORTS-1:0][31:0] bank_word;
  logic                      unused_wdata;

  assign unused_wdata = ^host_wdata[14:6];

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_sync_n = rst_s2;

  // host write decode
  always_comb begin
    wr_ctrl   = host_wr && (host_addr == OFS_CTRL);
    eng_start = wr_ctrl && host_wdata[START_BIT] && !host_wdata[MODE_BIT] && !eng_busy;
    index_d   = index_q;
    mode_d    = mode_q;
    cport_d   = cport_q;
    pen_d     = pen_q;
    if (host_wr && (host_addr == OFS_INDEX)) begin
      index_d = host_wdata[IDX_W-1:0];
    end
    if (wr_ctrl && !eng_busy) begin
      mode_d  = host_wdata[MODE_BIT];
      cport_d = host_wdata[PFLD_W-1:0];
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (host_wr && (host_addr == OFS_PCFG + HADDR_W'(p))) begin
        pen_d[p] = host_wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      index_q <= '0;
      mode_q  <= 1'b0;
      cport_q <= '0;
      pen_q   <= '0;
    end else begin
      index_q <= index_d;
      mode_q  <= mode_d;
      cport_q <= cport_d;
      pen_q   <= pen_d;
    end
  end

  // host read mux
  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      OFS_VAL_LO: host_rdata = eng_value[15:0];
      OFS_VAL_HI: host_rdata = eng_value[31:16];
      OFS_INDEX:  host_rdata = REG_W'(index_q);
      OFS_CTRL:   host_rdata = {eng_busy, 9'd0, mode_q, cport_q};
      default: begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (host_addr == OFS_PCFG + HADDR_W'(p)) begin
            host_rdata = {15'd0, pen_q[p]};
          end
        end
      end
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : g_bank
      stat_port_bank #(
        .NUM_EVT (NUM_EVT),
        .LEN_W   (LEN_W),
        .SLOT_W  (SLOT_W)
      ) u_bank (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .cnt_en   (pen_q[g]),
        .evt_stb  (evt_stb[g*NUM_EVT +: NUM_EVT]),
        .byte_vld (byte_vld[g]),
        .byte_len (byte_len[g*LEN_W +: LEN_W]),
        .rd_slot  (rd_slot),
        .rd_word  (bank_word[g])
      );
    end
  endgenerate

  stat_read_engine #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_EVT   (NUM_EVT),
    .SLOT_W    (SLOT_W),
    .BYTE_IDX  (BYTE_IDX)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (eng_start),
    .req_port  (host_wdata[PFLD_W-1:0]),
    .req_idx   (index_q),
    .bank_word (bank_word),
    .rd_slot   (rd_slot),
    .busy      (eng_busy),
    .value     (eng_value)
  );
endmodule

// File: rtl/stat_counter_window_chk.sv
module stat_counter_window_chk
  import stat_win_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               host_wr,
  input logic [HADDR_W-1:0] host_addr,
  input logic [REG_W-1:0]   host_wdata,
  input logic               eng_busy,
  input logic [31:0]        eng_value
);
  logic ctrl_wr;
  logic unused_bits;
  assign ctrl_wr     = host_wr && (host_addr == OFS_CTRL);
  assign unused_bits = ^{host_wdata[14:6], host_wdata[4:0]};

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && host_wdata[START_BIT] && !host_wdata[MODE_BIT] && !eng_busy) |=> eng_busy); // R2

  AST_BUSY_HOLDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |=> eng_busy); // R2

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && $past(eng_busy)) |=> !eng_busy); // R8

  AST_MODE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && host_wdata[MODE_BIT] && !eng_busy) |=> !eng_busy); // R7

  AST_VALUE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_busy && !$past(eng_busy)) |-> $stable(eng_value)); // R2
endmodule

bind stat_counter_window stat_counter_window_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .eng_busy   (eng_busy),
  .eng_value  (eng_value)
);

// File: tb/stat_counter_window_test.sv
module stat_counter_window_test;
  import stat_win_pkg::*;

  localparam int NP = 4;
  localparam int NE = 4;
  localparam int LW = 16;

  logic                 clk;
  logic                 rst_n;
  logic                 host_wr;
  logic [5:0]           host_addr;
  logic [15:0]          host_wdata;
  logic [15:0]          host_rdata;
  logic [NP*NE-1:0]     evt_stb;
  logic [NP-1:0]        byte_vld;
  logic [NP*LW-1:0]     byte_len;

  int n_cmp;
  int n_bad;
  logic [31:0] exp_evt [NP][NE];
  logic [63:0] exp_byte [NP];
  logic [31:0] got;
  logic [31:0] last_val;
  logic [15:0] r16;

  stat_counter_window #(.NUM_PORTS(NP), .NUM_EVT(NE), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_stb(evt_stb),
    .byte_vld(byte_vld), .byte_len(byte_len)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic rd_val(output logic [31:0] v);
    logic [15:0] lo, hi;
    rd(OFS_VAL_LO, lo);
    rd(OFS_VAL_HI, hi);
    v = {hi, lo};
  endtask

  task automatic fetch(input int p, input int i, output logic [31:0] v);
    wr(OFS_INDEX, 16'(i));
    wr(OFS_CTRL, 16'h8000 | 16'(p));
    @(negedge clk);
    @(negedge clk);
    rd_val(v);
  endtask

  function automatic logic [31:0] expv(input int p, input int i);
    if (p >= NP) return 32'h0;
    if (i < NE) return exp_evt[p][i];
    if (i == 36) return exp_byte[p][31:0];
    if (i == 37) return exp_byte[p][63:32];
    return 32'h0;
  endfunction

  task automatic pulse(input int p, input int e, input int n, input bit en);
    evt_stb[p*NE+e] = 1'b1;
    repeat (n) @(negedge clk);
    evt_stb[p*NE+e] = 1'b0;
    if (en) exp_evt[p][e] = exp_evt[p][e] + 32'(n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    evt_stb = '0; byte_vld = '0; byte_len = '0;
    for (int p = 0; p < NP; p++) begin
      exp_byte[p] = '0;
      for (int e = 0; e < NE; e++) exp_evt[p][e] = '0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(OFS_CTRL, r16);   chk("R1 ctrl", 32'(r16), 32'h0);
    rd_val(got);         chk("R1 value", got, 32'h0);
    rd(OFS_PCFG, r16);   chk("R1 enable", 32'(r16), 32'h0);

    // R4 gating: strobes with enable clear are ignored
    pulse(0, 0, 3, 1'b0);
    fetch(0, 0, got);    chk("R4 disabled port", got, 32'h0);

    for (int p = 0; p < NP; p++) wr(OFS_PCFG + 6'(p), 16'h1);

    // R4 sweep of event counters with distinct counts
    for (int p = 0; p < NP; p++)
      for (int e = 0; e < NE; e++)
        pulse(p, e, p*5 + e*3 + 1, 1'b1);

    // R5 byte counters on all ports at once
    for (int p = 0; p < NP; p++) byte_len[p*LW +: LW] = 16'(p*100 + 13);
    byte_vld = '1;
    repeat (3) @(negedge clk);
    byte_vld = '0;
    for (int p = 0; p < NP; p++) exp_byte[p] = exp_byte[p] + 64'(3*(p*100 + 13));

    // R3 R4 R5 R9 full index sweep, including one port beyond the last
    for (int p = 0; p <= NP; p++) begin
      for (int i = 0; i < 40; i++) begin
        fetch(p, i, got);
        if (p >= NP) chk("R9 port out of range", got, 32'h0);
        else if (i < NE) chk("R4 event counter", got, expv(p, i));
        else if (i == 36 || i == 37) chk("R5 byte counter", got, expv(p, i));
        else chk("R9 empty index", got, 32'h0);
      end
    end
    fetch(1, 1, got);    chk("R3 split value", got, expv(1, 1));
    fetch(1, 6'h30, got); chk("R9 index above range", got, 32'h0);

    // R2 cycle timing
    fetch(2, 3, last_val);
    wr(OFS_INDEX, 16'd1);
    wr(OFS_CTRL, 16'h8002);
    rd(OFS_CTRL, r16);   chk("R2 busy cycle 1", 32'(r16[15]), 32'h1);
    rd_val(got);         chk("R2 value held cycle 1", got, last_val);
    @(negedge clk);
    rd(OFS_CTRL, r16);   chk("R2 busy cycle 2", 32'(r16[15]), 32'h1);
    rd_val(got);         chk("R2 value held cycle 2", got, last_val);
    @(negedge clk);
    rd(OFS_CTRL, r16);   chk("R2 busy cleared", 32'(r16[15]), 32'h0);
    rd_val(got);         chk("R2 value at done", got, expv(2, 1));
    rd(OFS_VAL_HI, r16); chk("R3 high half", 32'(r16), {16'h0, expv(2, 1)[31:16]});

    // R6 collision with an increment
    wr(OFS_INDEX, 16'd1);
    host_wr = 1'b1; host_addr = OFS_CTRL; host_wdata = 16'h8000;
    @(negedge clk);
    host_wr = 1'b0;
    evt_stb[0*NE+1] = 1'b1;
    @(negedge clk);
    evt_stb[0*NE+1] = 1'b0;
    @(negedge clk);
    rd_val(got);         chk("R6 pre-increment value", got, exp_evt[0][1]);
    exp_evt[0][1] = exp_evt[0][1] + 32'd1;
    fetch(0, 1, got);    chk("R6 increment kept", got, exp_evt[0][1]);

    // R7 mode bit set starts nothing
    fetch(3, 2, last_val);
    wr(OFS_INDEX, 16'd0);
    wr(OFS_CTRL, 16'h8022);
    rd(OFS_CTRL, r16);   chk("R7 no busy", 32'(r16), 32'h0022);
    repeat (3) @(negedge clk);
    rd_val(got);         chk("R7 value kept", got, last_val);

    // R8 writes during a busy read are ignored
    wr(OFS_INDEX, 16'd0);
    wr(OFS_CTRL, 16'h8000);
    wr(OFS_CTRL, 16'h8001);
    wr(OFS_INDEX, 16'd2);
    rd(OFS_CTRL, r16);   chk("R8 busy done, port kept", 32'(r16), 32'h0);
    rd_val(got);         chk("R8 original target", got, expv(0, 0));
    @(negedge clk);
    rd(OFS_CTRL, r16);   chk("R8 no restart", 32'(r16[15]), 32'h0);

    // R5 carry from low word into high word
    byte_len[3*LW +: LW] = 16'hFFFF;
    byte_vld[3] = 1'b1;
    repeat (65537) @(negedge clk);
    byte_len[3*LW +: LW] = 16'd2;
    @(negedge clk);
    byte_vld[3] = 1'b0;
    exp_byte[3] = exp_byte[3] + 64'h0000_0000_FFFF_FFFF + 64'd2;
    fetch(3, 36, got);   chk("R5 carry low word", got, exp_byte[3][31:0]);
    fetch(3, 37, got);   chk("R5 carry high word", got, exp_byte[3][63:32]);
    fetch(2, 37, got);   chk("R5 other port high word", got, exp_byte[2][63:32]);

    summary();
    $finish;
  end
endmodule